// File: doc/BRIEF.md
# Paged Data Window Address Generator

This block produces the effective address for register-indirect data accesses whose address falls in the upper half of a 16-bit data space. That upper half is a window onto a larger paged space. Two page registers back the window: one is used by reads and the other by writes. Because they are separate, a single move can read from one page and write to a different one.

When a pre- or post-modified access steps across the edge of the window, the block moves the active page register up or down by one. It then puts the address back inside the window, so software sees one linear extended space. A small set of boundary pages breaks this rule: at those pages the access drops into the unpaged lower half instead. Register-offset, modulo and bit-reversed accesses never touch the page registers; they wrap inside the current page.

The effective address, the base-register writeback value and an address-error trap are combinational from the access inputs and the current page registers. Page updates take effect on the clock edge that commits the access, which is the same edge as the base-register writeback. A configuration port loads either page register directly.

Top module: `pdw_addr_gen`

## Requirements
- R1: There are two independent 10-bit page registers, a read page and a write page, and both reset to 0x001. A configuration load with select 0 writes the read page and select 1 writes the write page. An access with `acc_write_i`=0 can change only the read page, and an access with `acc_write_i`=1 can change only the write page.
- R2: Mode codes select the outputs as follows. Code 0 (plain) gives `ea_o` = `wb_addr_o` = base. Codes 1 (pre-increment) and 2 (pre-decrement) give `ea_o` = `wb_addr_o` = modified address. Codes 3 (post-increment) and 4 (post-decrement) give `ea_o` = base and `wb_addr_o` = modified address. Code 5 (register offset) gives `ea_o` = base + offset and `wb_addr_o` = base. Codes 6 (modulo) and 7 (bit-reversed) behave like post-increment by the step.
- R3: A crossing is detected only when bit 15 of the base is 1. Overflow is a carry out of bit 15 when adding, and underflow is the modified address having bit 15 clear after a decrement. For a base with bit 15 clear, the result is plain 16-bit arithmetic and no page changes.
- R4: A normal overflow in modes 1 and 3 increments the active page and sets bit 15 of the modified address. This includes read page 0x2FF, which goes to 0x300.
- R5: A normal underflow in modes 2 and 4 decrements the active page and sets bit 15 of the modified address. This includes read page 0x300, which goes to 0x2FF.
- R6: In modes 5, 6 and 7, an overflow sets bit 15 of the computed address and leaves both page registers unchanged.
- R7: An overflow at page 0x1FF (read or write), or a read overflow at page 0x3FF, leaves the page unchanged and leaves bit 15 of the modified address clear.
- R8: An underflow at page 0x001 (read or write), or a read underflow at page 0x200, leaves the page unchanged and leaves bit 15 of the modified address clear.
- R9: `trap_o` is 1 for a valid access when bit 15 of `ea_o` is 1 and the page used is 0x000, or when bit 15 of `ea_o` is 1, the access is a write, and the page used is 0x200 or above. The page used is the updated page for modes 1 and 2, and the current page otherwise.
- R10: An access that traps changes neither page register.
- R11: `ea_o`, `wb_addr_o` and `trap_o` are valid in the same cycle as the access inputs, and page registers change at the next rising edge. A configuration load wins over an access update to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid_i | input | 1 | Access is being committed this cycle |
| acc_mode_i | input | 3 | Addressing mode code (R2) |
| acc_write_i | input | 1 | 1 = write access (write page), 0 = read (read page) |
| acc_base_i | input | 16 | Base register value |
| acc_step_i | input | 4 | Increment/decrement step size |
| acc_ofs_i | input | 16 | Offset register value for mode 5 |
| cfg_we_i | input | 1 | Direct page register load |
| cfg_sel_i | input | 1 | Load target: 0 read page, 1 write page |
| cfg_page_i | input | 10 | Page value to load |
| ea_o | output | 16 | Effective address |
| wb_addr_o | output | 16 | Base register writeback value |
| trap_o | output | 1 | Address-error trap |
| rd_page_o | output | 10 | Read page register |
| wr_page_o | output | 10 | Write page register |

## Verification
The effective address, writeback value and trap are combinational, so the bench drives each access just after a falling edge and compares them, a couple of time units later, in that same cycle. A page change is due one rising edge later. The reference model applies its own page update at that edge, and the bench compares both page outputs at the next sample point, before the following access can disturb them. Every boundary page is also exercised in a long random run. In that run, every output is compared in every cycle.

// File: rtl/pdw_pkg.sv
// Package: shared mode codes and decoded mode controls for the paged
// data window address generator. Assumes a 3-bit mode field.
package pdw_pkg;

    typedef enum logic [2:0] {
        AM_PLAIN    = 3'd0,
        AM_PRE_INC  = 3'd1,
        AM_PRE_DEC  = 3'd2,
        AM_POST_INC = 3'd3,
        AM_POST_DEC = 3'd4,
        AM_REG_OFS  = 3'd5,
        AM_MODULO   = 3'd6,
        AM_BITREV   = 3'd7
    } addr_mode_e;

    typedef struct packed {
        logic inc;    // address moves up by the step
        logic dec;    // address moves down by the step
        logic ofs;    // address is base plus offset register
        logic pre;    // access uses the modified address
        logic wrap;   // crossing wraps in page, page never moves
    } mode_ctl_t;

    // Turns a mode code into independent control flags.
    function automatic mode_ctl_t decode_mode(addr_mode_e m);
        mode_ctl_t c;
        c.inc  = (m == AM_PRE_INC) || (m == AM_POST_INC) ||
                 (m == AM_MODULO)  || (m == AM_BITREV);
        c.dec  = (m == AM_PRE_DEC) || (m == AM_POST_DEC);
        c.ofs  = (m == AM_REG_OFS);
        c.pre  = (m == AM_PRE_INC) || (m == AM_PRE_DEC);
        c.wrap = (m == AM_REG_OFS) || (m == AM_MODULO) || (m == AM_BITREV);
        return c;
    endfunction

endpackage

// File: rtl/pdw_arith.sv
// Module: pdw_arith
// Computes the raw modified address and flags window crossings.
// Assumes the window is the upper half of the address space (top bit set)
// and that the step is far smaller than the window.
module pdw_arith
    import pdw_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [SW-1:0] step_i,
    input  logic [AW-1:0] ofs_i,
    input  mode_ctl_t     ctl_i,
    output logic [AW-1:0] raw_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int TOP = AW - 1;

    logic [AW:0] step_ext;
    logic [AW:0] addend;
    logic [AW:0] sum;
    logic [AW:0] dif;
    logic        windowed;

    // Forms the extended operands and both arithmetic results.
    always_comb begin
        step_ext = {{(AW + 1 - SW){1'b0}}, step_i};
        addend   = ctl_i.ofs ? {1'b0, ofs_i} : step_ext;
        sum      = {1'b0, base_i} + addend;
        dif      = {1'b0, base_i} - step_ext;
        windowed = base_i[TOP];
    end

    // Picks the raw result and raises the crossing flags.
    always_comb begin
        if (ctl_i.dec) begin
            raw_o = dif[AW-1:0];
        end else if (ctl_i.inc || ctl_i.ofs) begin
            raw_o = sum[AW-1:0];
        end else begin
            raw_o = base_i;
        end
        ovf_o = windowed && (ctl_i.inc || ctl_i.ofs) && sum[AW];
        unf_o = windowed && ctl_i.dec && !dif[TOP];
    end

endmodule

// File: rtl/pdw_boundary.sv
// Module: pdw_boundary
// Decides the next page and whether the window bit is restored after a
// crossing, including the pages where the window is left instead.
// Assumes the page space splits into an extended-data half and a
// program-space half, the latter split again into low and high halves.
module pdw_boundary #(
    parameter int PW = 10
) (
    input  logic          ovf_i,
    input  logic          unf_i,
    input  logic          wrap_i,
    input  logic          is_write_i,
    input  logic [PW-1:0] act_page_i,
    output logic [PW-1:0] next_page_o,
    output logic          hi_set_o
);

    localparam logic [PW-1:0] PG_FIRST    = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] PG_EDS_LAST = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] PG_PS_FIRST = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] PG_PS_LAST  = {PW{1'b1}};

    logic hold_ovf;
    logic hold_unf;

    // Flags the pages at which a crossing leaves the window.
    always_comb begin
        hold_ovf = (act_page_i == PG_EDS_LAST) ||
                   (!is_write_i && (act_page_i == PG_PS_LAST));
        hold_unf = (act_page_i == PG_FIRST) ||
                   (!is_write_i && (act_page_i == PG_PS_FIRST));
    end

    // Chooses next page and window-bit restore for each crossing kind.
    always_comb begin
        next_page_o = act_page_i;
        hi_set_o    = 1'b0;
        if (ovf_i || unf_i) begin
            if (wrap_i) begin
                hi_set_o = 1'b1;
            end else if (ovf_i) begin
                if (!hold_ovf) begin
                    next_page_o = act_page_i + 1'b1;
                    hi_set_o    = 1'b1;
                end
            end else begin
                if (!hold_unf) begin
                    next_page_o = act_page_i - 1'b1;
                    hi_set_o    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pdw_page_regs.sv
// Module: pdw_page_regs
// Holds the read page (index 0) and write page (index 1). A direct load
// has priority over an access update to the same register.
module pdw_page_regs #(
    parameter int            PW       = 10,
    parameter logic [PW-1:0] RST_PAGE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic          cfg_sel_i,
    input  logic [PW-1:0] cfg_page_i,
    input  logic          upd_en_i,
    input  logic          upd_sel_i,
    input  logic [PW-1:0] upd_page_i,
    output logic [PW-1:0] rd_page_o,
    output logic [PW-1:0] wr_page_o
);

    localparam int NREG = 2;

    logic [PW-1:0] page_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_page
        // Loads, updates or holds one page register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_q[g] <= RST_PAGE;
            end else if (cfg_we_i && (cfg_sel_i == 1'(g))) begin
                page_q[g] <= cfg_page_i;
            end else if (upd_en_i && (upd_sel_i == 1'(g))) begin
                page_q[g] <= upd_page_i;
            end
        end
    end

    assign rd_page_o = page_q[0];
    assign wr_page_o = page_q[1];

endmodule

// File: rtl/pdw_addr_gen.sv
// Module: pdw_addr_gen
// Effective-address generator for register-indirect accesses through a
// paged upper data window. EA, writeback and trap are combinational;
// page registers commit at the edge that commits the access.
// Assumes the caller holds inputs stable through the cycle.
module pdw_addr_gen
    import pdw_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 10,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid_i,
    input  logic [2:0]    acc_mode_i,
    input  logic          acc_write_i,
    input  logic [AW-1:0] acc_base_i,
    input  logic [SW-1:0] acc_step_i,
    input  logic [AW-1:0] acc_ofs_i,
    input  logic          cfg_we_i,
    input  logic          cfg_sel_i,
    input  logic [PW-1:0] cfg_page_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] wb_addr_o,
    output logic          trap_o,
    output logic [PW-1:0] rd_page_o,
    output logic [PW-1:0] wr_page_o
);

    localparam int TOP = AW - 1;

    mode_ctl_t     ctl;
    logic [AW-1:0] raw;
    logic          ovf;
    logic          unf;
    logic [PW-1:0] act_page;
    logic [PW-1:0] next_page;
    logic          hi_set;
    logic [AW-1:0] adj;
    logic [PW-1:0] use_page;
    logic          upd_en;

    // Decodes the mode and selects the page register this access uses.
    always_comb begin
        ctl      = decode_mode(addr_mode_e'(acc_mode_i));
        act_page = acc_write_i ? wr_page_o : rd_page_o;
    end

    pdw_arith #(.AW(AW), .SW(SW)) i_arith (
        .base_i (acc_base_i),
        .step_i (acc_step_i),
        .ofs_i  (acc_ofs_i),
        .ctl_i  (ctl),
        .raw_o  (raw),
        .ovf_o  (ovf),
        .unf_o  (unf)
    );

    pdw_boundary #(.PW(PW)) i_bound (
        .ovf_i       (ovf),
        .unf_i       (unf),
        .wrap_i      (ctl.wrap),
        .is_write_i  (acc_write_i),
        .act_page_i  (act_page),
        .next_page_o (next_page),
        .hi_set_o    (hi_set)
    );

    // Builds the adjusted address and routes it to EA and writeback.
    always_comb begin
        adj       = {hi_set | raw[TOP], raw[TOP-1:0]};
        ea_o      = (ctl.pre || ctl.ofs) ? adj : acc_base_i;
        wb_addr_o = (ctl.ofs || !(ctl.inc || ctl.dec)) ? acc_base_i : adj;
    end

    // Raises the trap on the page actually used and gates the page update.
    always_comb begin
        use_page = ctl.pre ? next_page : act_page;
        trap_o   = acc_valid_i && ea_o[TOP] &&
                   ((use_page == '0) || (acc_write_i && use_page[PW-1]));
        upd_en   = acc_valid_i && !trap_o && (next_page != act_page);
    end

    pdw_page_regs #(.PW(PW)) i_pages (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_page_i (cfg_page_i),
        .upd_en_i   (upd_en),
        .upd_sel_i  (acc_write_i),
        .upd_page_i (next_page),
        .rd_page_o  (rd_page_o),
        .wr_page_o  (wr_page_o)
    );

endmodule

// File: rtl/pdw_addr_gen_chk.sv
// Module: pdw_addr_gen_chk
// Temporal checks on the address generator ports, bound into the top.
module pdw_addr_gen_chk #(
    parameter int AW = 16,
    parameter int PW = 10,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid_i,
    input logic [2:0]    acc_mode_i,
    input logic          acc_write_i,
    input logic [AW-1:0] acc_base_i,
    input logic [SW-1:0] acc_step_i,
    input logic          cfg_we_i,
    input logic [AW-1:0] ea_o,
    input logic [AW-1:0] wb_addr_o,
    input logic          trap_o,
    input logic [PW-1:0] rd_page_o,
    input logic [PW-1:0] wr_page_o
);

    AST_PLAIN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_mode_i == 3'd0) |-> (ea_o == acc_base_i && wb_addr_o == acc_base_i)); // R2

    AST_NO_WINDOW_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && !acc_base_i[AW-1]) |=> ($stable(rd_page_o) && $stable(wr_page_o))); // R3

    AST_WRAP_MODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && acc_mode_i >= 3'd5) |=> ($stable(rd_page_o) && $stable(wr_page_o))); // R6

    AST_WRITE_KEEPS_RDPAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && acc_write_i) |=> $stable(rd_page_o)); // R1

    AST_READ_KEEPS_WRPAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && !acc_write_i) |=> $stable(wr_page_o)); // R1

    AST_TRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (acc_valid_i && ea_o[AW-1])); // R9

    AST_TRAP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && trap_o) |=> ($stable(rd_page_o) && $stable(wr_page_o))); // R10

    AST_PAGE_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> (rd_page_o == $past(rd_page_o) ||
                       rd_page_o == $past(rd_page_o) + 1'b1 ||
                       rd_page_o == $past(rd_page_o) - 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we_i && !acc_valid_i) |=> ($stable(rd_page_o) && $stable(wr_page_o))); // R11

endmodule

bind pdw_addr_gen pdw_addr_gen_chk #(.AW(AW), .PW(PW), .SW(SW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid_i),
    .acc_mode_i  (acc_mode_i),
    .acc_write_i (acc_write_i),
    .acc_base_i  (acc_base_i),
    .acc_step_i  (acc_step_i),
    .cfg_we_i    (cfg_we_i),
    .ea_o        (ea_o),
    .wb_addr_o   (wb_addr_o),
    .trap_o      (trap_o),
    .rd_page_o   (rd_page_o),
    .wr_page_o   (wr_page_o)
);

// File: tb/test_pdw_addr_gen.sv
// Bench: behavioural reference model compared on every clock.
module test_pdw_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [2:0]  acc_mode_i = '0;
    logic        acc_write_i = 1'b0;
    logic [15:0] acc_base_i = '0;
    logic [3:0]  acc_step_i = '0;
    logic [15:0] acc_ofs_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [9:0]  cfg_page_i = '0;
    logic [15:0] ea_o;
    logic [15:0] wb_addr_o;
    logic        trap_o;
    logic [9:0]  rd_page_o;
    logic [9:0]  wr_page_o;

    int n_tests = 0;
    int n_fail = 0;
    int m_rd = 1;
    int m_wr = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdw_addr_gen i_pdw_addr_gen (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_mode_i(acc_mode_i),
        .acc_write_i(acc_write_i), .acc_base_i(acc_base_i), .acc_step_i(acc_step_i),
        .acc_ofs_i(acc_ofs_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_page_i(cfg_page_i), .ea_o(ea_o), .wb_addr_o(wb_addr_o), .trap_o(trap_o),
        .rd_page_o(rd_page_o), .wr_page_o(wr_page_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference: from the requirements, returns outputs and next pages.
    task automatic model(output int e_ea, output int e_wb, output int e_tr,
                         output int n_rd, output int n_wr);
        int md = int'(acc_mode_i);
        int b = int'(acc_base_i);
        int wr = int'(acc_write_i);
        int act = wr ? m_wr : m_rd;
        bit pre = (md == 1 || md == 2);
        bit inc = (md == 1 || md == 3 || md == 6 || md == 7);
        bit dec = (md == 2 || md == 4);
        bit ofs = (md == 5);
        bit wrp = (md >= 5);
        bit win = (b >= 32768);
        int m = b;
        int np = act;
        int accp;
        bit ov, un;
        if (ofs) m = b + int'(acc_ofs_i);
        else if (inc) m = b + int'(acc_step_i);
        else if (dec) m = b - int'(acc_step_i);
        ov = win && (inc || ofs) && (m >= 65536);
        un = win && dec && ((m & 32768) == 0);
        m = m & 16'hFFFF;
        if (ov || un) begin
            if (wrp) m = m | 32768;
            else if (ov) begin
                if (!(act == 'h1FF || (!wr && act == 'h3FF))) begin
                    np = act + 1; m = m | 32768;
                end
            end else begin
                if (!(act == 1 || (!wr && act == 'h200))) begin
                    np = act - 1; m = m | 32768;
                end
            end
        end
        np = np & 'h3FF;
        e_ea = (pre || ofs) ? m : b;
        e_wb = (ofs || !(inc || dec)) ? b : m;
        accp = pre ? np : act;
        e_tr = (acc_valid_i && (e_ea >= 32768) &&
                (accp == 0 || (wr && accp >= 'h200))) ? 1 : 0;
        n_rd = m_rd; n_wr = m_wr;
        if (acc_valid_i && !e_tr) begin
            if (wr) n_wr = np; else n_rd = np;
        end
        if (cfg_we_i) begin
            if (cfg_sel_i) n_wr = int'(cfg_page_i); else n_rd = int'(cfg_page_i);
        end
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge.
    task automatic run(string tag);
        int e_ea, e_wb, e_tr, n_rd, n_wr;
        #2;
        model(e_ea, e_wb, e_tr, n_rd, n_wr);
        chk(tag, "rd_page", int'(rd_page_o), m_rd);
        chk(tag, "wr_page", int'(wr_page_o), m_wr);
        chk(tag, "trap", int'(trap_o), e_tr);
        if (acc_valid_i) begin
            chk(tag, "ea", int'(ea_o), e_ea);
            chk(tag, "wb", int'(wb_addr_o), e_wb);
        end
        @(posedge clk);
        m_rd = n_rd; m_wr = n_wr;
        @(negedge clk);
    endtask

    task automatic acc(string tag, int md, bit wr, int base, int stp, int ofs);
        acc_valid_i = 1'b1; acc_mode_i = 3'(md); acc_write_i = wr;
        acc_base_i = 16'(base); acc_step_i = 4'(stp); acc_ofs_i = 16'(ofs);
        cfg_we_i = 1'b0;
        run(tag);
        acc_valid_i = 1'b0;
    endtask

    task automatic setpg(bit sel, int pg);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_page_i = 10'(pg);
        run("R1");
        cfg_we_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        run("R1");                                    // R1 reset pages 0x001
        acc("R2", 0, 0, 'h1234, 2, 0);                // plain
        acc("R3", 3, 0, 'h7FFE, 4, 0);                // unwindowed, no page move
        acc("R2", 1, 0, 'h8100, 2, 0);                // pre-inc in window
        acc("R2", 4, 0, 'h9000, 2, 0);                // post-dec in window
        setpg(0, 'h005);
        acc("R4", 3, 0, 'hFFFE, 2, 0);                // post-inc overflow
        acc("R4", 1, 0, 'hFFFF, 1, 0);                // pre-inc overflow
        run("R4");
        setpg(0, 'h010);
        acc("R5", 2, 0, 'h8000, 2, 0);                // pre-dec underflow
        acc("R5", 4, 0, 'h8001, 2, 0);
        run("R5");
        setpg(1, 'h050);
        acc("R1", 3, 1, 'hFFFF, 1, 0);                // write moves write page only
        run("R1");
        acc("R6", 5, 0, 'hFF00, 0, 'h0200);           // register offset wrap
        acc("R6", 6, 0, 'hFFFE, 4, 0);                // modulo wrap
        acc("R6", 7, 1, 'hFFFF, 1, 0);                // bit-reversed wrap
        run("R6");
        setpg(0, 'h1FF);
        acc("R7", 3, 0, 'hFFFF, 1, 0);                // last extended page, read
        setpg(1, 'h1FF);
        acc("R7", 1, 1, 'hFFFE, 2, 0);                // last extended page, write
        setpg(0, 'h3FF);
        acc("R7", 1, 0, 'hFFFF, 1, 0);
        setpg(0, 'h2FF);
        acc("R4", 3, 0, 'hFFFF, 1, 0);                // 0x2FF -> 0x300
        run("R4");
        acc("R5", 2, 0, 'h8000, 1, 0);                // 0x300 -> 0x2FF
        run("R5");
        setpg(0, 'h001);
        acc("R8", 4, 0, 'h8000, 2, 0);
        setpg(0, 'h200);
        acc("R8", 2, 0, 'h8001, 2, 0);
        setpg(1, 'h001);
        acc("R8", 2, 1, 'h8000, 1, 0);
        run("R8");
        setpg(0, 'h000);
        acc("R9", 0, 0, 'h8000, 0, 0);                // page 0 window trap
        acc("R10", 4, 0, 'h8000, 2, 0);               // trapped post-dec keeps page
        run("R10");
        setpg(1, 'h250);
        acc("R9", 0, 1, 'hA000, 0, 0);                // write to program space
        acc("R10", 3, 1, 'hFFFF, 1, 0);
        run("R10");
        acc("R9", 0, 1, 'h2000, 0, 0);                // outside window: no trap
        // R11: load and access on the same register in one cycle
        setpg(0, 'h040);
        acc_valid_i = 1'b1; acc_mode_i = 3'd3; acc_write_i = 1'b0;
        acc_base_i = 16'hFFFF; acc_step_i = 4'd1;
        cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_page_i = 10'h123;
        run("R11");
        acc_valid_i = 1'b0; cfg_we_i = 1'b0;
        run("R11");
        for (int i = 0; i < 600; i++) begin
            int sel = $urandom_range(0, 9);
            int pg;
            case (sel)
                0: pg = 'h000;  1: pg = 'h001;  2: pg = 'h1FF;  3: pg = 'h200;
                4: pg = 'h2FF;  5: pg = 'h300;  6: pg = 'h3FF;
                default: pg = $urandom_range(0, 1023);
            endcase
            if ((i % 4) == 0) setpg(1'($urandom_range(0, 1)), pg);
            acc("R3", $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535)
                    : (($urandom_range(0, 1) == 1) ? 65535 - $urandom_range(0, 15)
                                                   : 32768 + $urandom_range(0, 15)),
                $urandom_range(0, 15), $urandom_range(0, 65535));
        end
        run("R11");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule